// File: doc/BRIEF.md
# GPIO Edge Interrupt Cause Unit

This block watches a bank of up to 32 already-synchronized GPIO inputs for edges and turns them into interrupt causes. For each pin, software chooses whether a rising edge, a falling edge, or either edge counts. A detected edge sets that pin's bit in a sticky cause register. The bit stays set until software writes a 1 to it at the clear offset.

A separate event-enable vector selects which latched causes may reach the single interrupt line. That line is a level: the OR of all enabled causes. It is meant to be one of several sources wired onto a shared request. A read-only offset returns only the enabled causes, so a handler can find its pins in one read and then acknowledge them with one write.

Register access is a simple synchronous bus. Writes take effect at the clock edge where the write enable is high. Read data is a combinational function of the address.

Top module: `gpio_irq_cause`

## Requirements
- R1: After reset, every register reads zero and `irqOut` is low.
- R2: Offset 0x44 holds the rise-enable vector (bit n = pin n) and reads back what was written. A 0-to-1 change on a rise-enabled pin, seen between two consecutive clocks, sets cause bit n.
- R3: Offset 0x48 holds the fall-enable vector and reads back what was written. A 1-to-0 change on a fall-enabled pin sets cause bit n.
- R4: A pin with both its rise and fall bits set latches a cause on either edge.
- R5: An edge on a pin whose enable bit for that edge direction is clear sets no cause.
- R6: Cause bits stay set until cleared. Writing offset 0x98 clears exactly the bits written as 1, and bits written as 0 are unchanged. Reading 0x98 returns the raw cause vector.
- R7: If a new enabled edge and a clear of the same bit happen in the same cycle, the bit ends up set.
- R8: Offset 0x94 holds the event-enable vector. Offset 0x80 reads cause AND event-enable, and writes to 0x80 have no effect.
- R9: `irqOut` is high exactly when some cause bit is set whose event-enable bit is also set. It stays high until that bit is cleared or masked.
- R10: Reads from any offset other than 0x44, 0x48, 0x80, 0x94 and 0x98 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pinIn | input | NUM_PINS | Synchronized pin levels |
| regWrEn | input | 1 | Write strobe, captured at the rising clock edge |
| regAddr | input | ADDR_W | Byte offset of the register |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data for `regAddr`, combinational |
| irqOut | output | 1 | Level interrupt: OR of the enabled causes |

## Verification
A pin change applied before clock edge k is compared with its value from edge k-1. The resulting cause bit, and with it `irqOut` and the read views, is visible right after edge k. A register write also lands at the edge that samples the strobe. The bench therefore changes its inputs just after a rising edge and compares the outputs at the following falling edge against a behavioural model that advances on the same rising edge. Directed reads that follow an edge wait one full cycle before sampling, so each pipeline stage has settled.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Register offsets (bus byte addresses)
  localparam int OFS_RISE_EN   = 'h44;
  localparam int OFS_FALL_EN   = 'h48;
  localparam int OFS_MASKED    = 'h80;
  localparam int OFS_EVT_EN    = 'h94;
  localparam int OFS_CAUSE_CLR = 'h98;

  // Write strobes from the decoder to the datapath
  typedef struct packed {
    logic wrRise;
    logic wrFall;
    logic wrEvt;
    logic wrClr;
  } cfgStb_t;

  // Read view selector
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RISE,
    SEL_FALL,
    SEL_MASKED,
    SEL_EVT,
    SEL_RAW
  } rdSel_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output cfgStb_t             stb,
  output logic [NUM_PINS-1:0] wrMask,
  output rdSel_t              rdSel
);

  localparam logic [ADDR_W-1:0] A_RISE   = ADDR_W'(OFS_RISE_EN);
  localparam logic [ADDR_W-1:0] A_FALL   = ADDR_W'(OFS_FALL_EN);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFS_MASKED);
  localparam logic [ADDR_W-1:0] A_EVT    = ADDR_W'(OFS_EVT_EN);
  localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(OFS_CAUSE_CLR);

  assign wrMask = regWrData[NUM_PINS-1:0];

  // Address decode. The masked view is read-only and gets no write strobe.
  always_comb begin
    stb   = '0;
    rdSel = SEL_NONE;
    if (regAddr == A_RISE) begin
      rdSel      = SEL_RISE;
      stb.wrRise = regWrEn;
    end else if (regAddr == A_FALL) begin
      rdSel      = SEL_FALL;
      stb.wrFall = regWrEn;
    end else if (regAddr == A_MASKED) begin
      rdSel      = SEL_MASKED;
    end else if (regAddr == A_EVT) begin
      rdSel      = SEL_EVT;
      stb.wrEvt  = regWrEn;
    end else if (regAddr == A_CLR) begin
      rdSel      = SEL_RAW;
      stb.wrClr  = regWrEn;
    end
  end

endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pinIn,
  input  cfgStb_t             stb,
  input  logic [NUM_PINS-1:0] wrMask,
  output logic [NUM_PINS-1:0] riseEn,
  output logic [NUM_PINS-1:0] fallEn,
  output logic [NUM_PINS-1:0] evtEn,
  output logic [NUM_PINS-1:0] causeQ,
  output logic                irq
);

  logic [NUM_PINS-1:0] pinPrev;
  logic [NUM_PINS-1:0] edgeHit;

  // One slice per pin: enables, previous level, edge detect, sticky cause
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        riseEn[g]  <= 1'b0;
        fallEn[g]  <= 1'b0;
        evtEn[g]   <= 1'b0;
        pinPrev[g] <= 1'b0;
      end else begin
        if (stb.wrRise) riseEn[g] <= wrMask[g];
        if (stb.wrFall) fallEn[g] <= wrMask[g];
        if (stb.wrEvt)  evtEn[g]  <= wrMask[g];
        pinPrev[g] <= pinIn[g];
      end
    end

    assign edgeHit[g] = (riseEn[g] &  pinIn[g] & ~pinPrev[g]) |
                        (fallEn[g] & ~pinIn[g] &  pinPrev[g]);

    // A fresh edge overrides a same-cycle clear
    always_ff @(posedge clk) begin
      if (rst) causeQ[g] <= 1'b0;
      else     causeQ[g] <= edgeHit[g] | (causeQ[g] & ~(stb.wrClr & wrMask[g]));
    end
  end

  assign irq = |(causeQ & evtEn);

endmodule

// File: rtl/gpio_irq_cause.sv
module gpio_irq_cause
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic                irqOut
);

  cfgStb_t             stb;
  rdSel_t              rdSel;
  logic [NUM_PINS-1:0] wrMask;
  logic [NUM_PINS-1:0] riseEn, fallEn, evtEn, causeQ;

  gpio_irq_ctrl #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .stb      (stb),
    .wrMask   (wrMask),
    .rdSel    (rdSel)
  );

  gpio_irq_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .pinIn (pinIn),
    .stb   (stb),
    .wrMask(wrMask),
    .riseEn(riseEn),
    .fallEn(fallEn),
    .evtEn (evtEn),
    .causeQ(causeQ),
    .irq   (irqOut)
  );

  always_comb begin
    case (rdSel)
      SEL_RISE:   regRdData = DATA_W'(riseEn);
      SEL_FALL:   regRdData = DATA_W'(fallEn);
      SEL_MASKED: regRdData = DATA_W'(causeQ & evtEn);
      SEL_EVT:    regRdData = DATA_W'(evtEn);
      SEL_RAW:    regRdData = DATA_W'(causeQ);
      default:    regRdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_cause_chk.sv
module gpio_irq_cause_chk #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PINS-1:0] pinIn,
  input logic                regWrEn,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [DATA_W-1:0]   regWrData,
  input logic                irqOut,
  input logic [NUM_PINS-1:0] riseEn,
  input logic [NUM_PINS-1:0] fallEn,
  input logic [NUM_PINS-1:0] evtEn,
  input logic [NUM_PINS-1:0] causeQ
);

  logic                clrHit, evtHit;
  logic [NUM_PINS-1:0] clrMask, clrMaskQ, pinLast, edgeSeen;

  assign clrHit  = regWrEn && (regAddr == ADDR_W'('h98));
  assign evtHit  = regWrEn && (regAddr == ADDR_W'('h94));
  assign clrMask = clrHit ? regWrData[NUM_PINS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pinLast  <= '0;
      clrMaskQ <= '0;
    end else begin
      pinLast  <= pinIn;
      clrMaskQ <= clrMask;
    end
  end

  assign edgeSeen = (riseEn & pinIn & ~pinLast) | (fallEn & ~pinIn & pinLast);

  // R5: a cause bit only appears where an edge direction was enabled
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
    ((causeQ & ~$past(causeQ)) & ~($past(riseEn) | $past(fallEn))) == '0);

  // R6: a set cause bit only drops when it was written with 1 at the clear offset
  p_cause_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(causeQ) & ~clrMaskQ & ~causeQ) == '0);

  // R7: an edge beats a clear aimed at the same bit
  p_edge_wins_r7: assert property (@(posedge clk) disable iff (rst)
    ((edgeSeen & clrMask) != '0) |=>
      ((causeQ & $past(edgeSeen & clrMask)) == $past(edgeSeen & clrMask)));

  // R9: the line only asserts when some event enable is on
  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
    irqOut |-> (evtEn != '0));

  // R9: the level drops only after a clear or an event-enable write
  p_irq_level_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(irqOut) |-> $past(clrHit || evtHit));

endmodule

bind gpio_irq_cause gpio_irq_cause_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pinIn    (pinIn),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .regWrData(regWrData),
  .irqOut   (irqOut),
  .riseEn   (riseEn),
  .fallEn   (fallEn),
  .evtEn    (evtEn),
  .causeQ   (causeQ)
);

// File: tb/tb_gpio_irq_cause.sv
`timescale 1ns/1ps
module tb_gpio_irq_cause;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pinIn = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  gpio_irq_cause dut (
    .clk(clk), .rst(rst), .pinIn(pinIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  // Behavioural reference model
  logic [31:0] mRise, mFall, mEvt, mCause, mPrev;

  always @(posedge clk) begin
    if (rst) begin
      mRise <= 0; mFall <= 0; mEvt <= 0; mCause <= 0; mPrev <= 0;
    end else begin
      logic [31:0] nc;
      nc = mCause;
      if (regWrEn && regAddr == 8'h98) nc = nc & ~regWrData;
      for (int i = 0; i < 32; i++) begin
        if (mRise[i] && pinIn[i] && !mPrev[i]) nc[i] = 1'b1;
        if (mFall[i] && !pinIn[i] && mPrev[i]) nc[i] = 1'b1;
      end
      mCause <= nc;
      if (regWrEn && regAddr == 8'h44) mRise <= regWrData;
      if (regWrEn && regAddr == 8'h48) mFall <= regWrData;
      if (regWrEn && regAddr == 8'h94) mEvt  <= regWrData;
      mPrev <= pinIn;
    end
  end

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    case (a)
      8'h44:   return mRise;
      8'h48:   return mFall;
      8'h80:   return mCause & mEvt;
      8'h94:   return mEvt;
      8'h98:   return mCause;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagFor(input logic [7:0] a);
    case (a)
      8'h44:   return "R2";
      8'h48:   return "R3";
      8'h80:   return "R8";
      8'h94:   return "R8";
      8'h98:   return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(regRdData === modelRead(regAddr), tagFor(regAddr), regRdData, modelRead(regAddr));
      check(irqOut === ((mCause & mEvt) != 0), "R9", {31'b0, irqOut}, {31'b0, (mCause & mEvt) != 0});
    end
  end

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #2;
    regWrEn = 1'b0;
  endtask

  task automatic setPins(input logic [31:0] v);
    @(posedge clk); #2;
    pinIn = v;
  endtask

  task automatic expectRead(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #2;
    regAddr = a;
    @(negedge clk);
    check(regRdData === exp, tag, regRdData, exp);
  endtask

  task automatic expectIrq(input logic exp, input string tag);
    @(negedge clk);
    check(irqOut === exp, tag, {31'b0, irqOut}, {31'b0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;

    // R1: reset state
    expectRead(8'h44, 0, "R1");
    expectRead(8'h48, 0, "R1");
    expectRead(8'h94, 0, "R1");
    expectRead(8'h98, 0, "R1");
    expectRead(8'h80, 0, "R1");
    expectIrq(1'b0, "R1");

    // R2/R3 enable registers; bit 24 enabled for both edges (R4)
    busWrite(8'h44, 32'h0100000F);
    busWrite(8'h48, 32'h010000F0);
    expectRead(8'h44, 32'h0100000F, "R2");
    expectRead(8'h48, 32'h010000F0, "R3");

    // pin0 rises (rise-enabled), pin4 rises (only fall-enabled: R5)
    setPins(32'h00000011);
    expectRead(8'h98, 32'h00000001, "R2 R5");
    expectIrq(1'b0, "R9");
    expectRead(8'h80, 32'h0, "R8");

    busWrite(8'h94, 32'hFFFFFFFF);
    expectRead(8'h80, 32'h00000001, "R8");
    expectIrq(1'b1, "R9");

    setPins(32'h00000001);             // pin4 falls
    expectRead(8'h98, 32'h00000011, "R3");
    setPins(32'h01000001);             // pin24 rises
    expectRead(8'h98, 32'h01000011, "R4");
    busWrite(8'h98, 32'h01000000);
    expectRead(8'h98, 32'h00000011, "R6");
    busWrite(8'h98, 32'h00000000);
    expectRead(8'h98, 32'h00000011, "R6");
    setPins(32'h00000001);             // pin24 falls
    expectRead(8'h98, 32'h01000011, "R4");

    busWrite(8'h80, 32'hFFFFFFFF);     // read-only view, write ignored
    expectRead(8'h80, 32'h01000011, "R8");
    expectRead(8'h98, 32'h01000011, "R8");

    // R7: clear and new rising edge on pin0 in the same cycle
    setPins(32'h00000000);             // pin0 fall is not enabled
    @(posedge clk); #2;
    regWrEn = 1'b1; regAddr = 8'h98; regWrData = 32'h1; pinIn = 32'h1;
    @(posedge clk); #2;
    regWrEn = 1'b0;
    expectRead(8'h98, 32'h01000011, "R7");
    busWrite(8'h98, 32'h00000001);
    expectRead(8'h98, 32'h01000010, "R6");

    // R9 masking and clearing
    busWrite(8'h94, 32'h0);
    expectIrq(1'b0, "R9");
    expectRead(8'h80, 32'h0, "R8");
    expectRead(8'h98, 32'h01000010, "R9");
    busWrite(8'h94, 32'h00000010);
    expectIrq(1'b1, "R9");
    busWrite(8'h98, 32'hFFFFFFFF);
    expectIrq(1'b0, "R9");
    expectRead(8'h98, 32'h0, "R9");

    // R10 unmapped offsets
    expectRead(8'h40, 32'h0, "R10");
    expectRead(8'h9C, 32'h0, "R10");
    expectRead(8'h00, 32'h0, "R10");

    // Mixed traffic compared against the model every clock
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] addrs [6];
      addrs = '{8'h44, 8'h48, 8'h80, 8'h94, 8'h98, 8'h3C};
      @(posedge clk); #2;
      pinIn = pinIn ^ ($urandom & $urandom & $urandom);
      regAddr = addrs[$urandom % 6];
      regWrData = $urandom;
      regWrEn = (($urandom % 8) == 0);
    end
    @(posedge clk); #2;
    regWrEn = 1'b0;

    // R1: reset mid-run
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #2 rst = 1'b0;
    expectRead(8'h98, 32'h0, "R1");
    expectRead(8'h44, 32'h0, "R1");
    expectIrq(1'b0, "R1");

    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule